// File: doc/BRIEF.md
# Watermark-Interrupt Serial Port

This block is a register-mapped asynchronous serial port. Software writes bytes into an 8-entry transmit queue and reads received bytes from an 8-entry receive queue through a 32-bit register bus. Each frame is a start bit, eight data bits sent least significant bit first, and then one or two stop bits. No parity bit is used. The bit period is set by a 16-bit divisor.

The block has no separate status register. The "queue full" flag is bit 31 of a transmit-data read. The "queue empty" flag is bit 31 of a receive-data read. The single level interrupt comes from two FIFO-level conditions, not from per-character events. The transmit condition is "occupancy below a programmed count". The receive condition is "occupancy above a programmed count". Each condition has its own enable.

The register byte offsets, decoded from bus_addr[4:2], are:

| Offset | Register |
|--------|----------|
| 0x00 | Transmit data |
| 0x04 | Receive data |
| 0x08 | Transmit control |
| 0x0C | Receive control |
| 0x10 | Interrupt enable |
| 0x14 | Interrupt pending |
| 0x18 | Divisor |

Top module: `uart_wm`

## Requirements
- R1: After reset, ser_tx is high and irq is low. Reads return 0 for transmit data, control, enable, pending and divisor. A receive-data read returns 0x8000_0000, which means empty with the data field at 0.
- R2: A transmitted frame is a low start bit, then data bits 0..7, then a high stop bit. Each bit lasts divisor+1 clocks. With one stop bit, back-to-back frames start 10×(divisor+1) clocks apart.
- R3: When transmit-control bit 1 is 1, two stop bits are sent. Back-to-back frames then start 11×(divisor+1) clocks apart.
- R4: Transmission starts only while transmit-control bit 0 is 1. A write of bits [7:0] to offset 0x00 queues a byte. A read of offset 0x00 has bit 31 set when 8 bytes are queued. A write while full is dropped.
- R5: When receive-control bit 0 is 1, a frame with a high stop bit is queued. Reads of offset 0x04 return the bytes oldest first in [7:0], with bit 31 clear.
- R6: A frame whose stop bit is low is discarded. Any frame that arrives while reception is disabled is also discarded.
- R7: The receive queue holds 8 bytes. A byte that arrives while it is full is dropped.
- R8: Pending bit 0 (offset 0x14) is 1 exactly when the transmit occupancy is below the count in transmit-control bits [18:16].
- R9: Pending bit 1 is 1 exactly when the receive occupancy is above the count in receive-control bits [18:16].
- R10: irq is the OR over the enabled pending bits. Enable bit 0 (offset 0x10) gates the transmit condition and enable bit 1 gates the receive condition.
- R11: Only the implemented fields read back: divisor [15:0] at offset 0x18, and enable, stop select and count in the control registers.
- R12: A read of an empty receive queue returns 0x8000_0000 and leaves the queue unchanged. A byte received afterwards is read normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_req | input | 1 | Register access strobe, one access per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits [4:2] select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| ser_tx | output | 1 | Serial transmit line, idle high |
| ser_rx | input | 1 | Serial receive line, synchronised inside |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check the following on every cycle:
- The transmit line stays high whenever no frame is in progress.
- A write to a full transmit queue and a pop from an empty receive queue leave the occupancy unchanged.
- The receive occupancy never exceeds the depth.
- The interrupt never rises with no source enabled.
- An empty queue is consistent with the pending bits.

Only the bench scenarios can show the following:
- The serial bit order and the bit period.
- The frame spacing with one and with two stop bits.
- That a bad stop bit or a disabled receiver discards a frame.
- The exact watermark boundaries at occupancy 8 against count 7.

// File: rtl/uart_wm_pkg.sv
package uart_wm_pkg;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = DATA_W + 3;  // start + data + up to two stop bits

  localparam logic [2:0] SEL_TXD  = 3'd0;
  localparam logic [2:0] SEL_RXD  = 3'd1;
  localparam logic [2:0] SEL_TXC  = 3'd2;
  localparam logic [2:0] SEL_RXC  = 3'd3;
  localparam logic [2:0] SEL_IEN  = 3'd4;
  localparam logic [2:0] SEL_IPND = 3'd5;
  localparam logic [2:0] SEL_DIV  = 3'd6;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT
  } rx_state_e;
endpackage

// File: rtl/wm_fifo.sv
module wm_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH+1);
  localparam bit POW2 = (DEPTH & (DEPTH - 1)) == 0;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q, wr_nxt, rd_nxt;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  assign full    = (cnt_q == LW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign count   = cnt_q;
  assign rdata   = mem[rd_ptr_q];

  generate
    if (POW2) begin : g_pow2
      assign wr_nxt = wr_ptr_q + AW'(1);
      assign rd_nxt = rd_ptr_q + AW'(1);
    end else begin : g_wrap
      assign wr_nxt = (wr_ptr_q == AW'(DEPTH-1)) ? '0 : wr_ptr_q + AW'(1);
      assign rd_nxt = (rd_ptr_q == AW'(DEPTH-1)) ? '0 : rd_ptr_q + AW'(1);
    end
  endgenerate

  always_comb begin
    cnt_d = cnt_q;
    if (push_ok && !pop_ok)      cnt_d = cnt_q + LW'(1);
    else if (pop_ok && !push_ok) cnt_d = cnt_q - LW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= wr_nxt;
      if (pop_ok)  rd_ptr_q <= rd_nxt;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= wdata;
  end
endmodule

// File: rtl/wm_tx.sv
module wm_tx
  import uart_wm_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              two_stop,
  input  logic [DIV_W-1:0]  div,
  input  logic              fifo_empty,
  input  logic [DATA_W-1:0] fifo_data,
  output logic              pop,
  output logic              busy,
  output logic              line
);
  logic               busy_q, busy_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [3:0]         nb_q, nb_d;
  logic [DIV_W-1:0]   cnt_q, cnt_d;
  logic               tick, last, start;

  assign tick  = busy_q && (cnt_q == '0);
  assign last  = tick && (nb_q == 4'd1);
  assign start = en && !fifo_empty && (!busy_q || last);

  always_comb begin
    busy_d = busy_q;
    sh_d   = sh_q;
    nb_d   = nb_q;
    cnt_d  = cnt_q;
    if (start) begin
      busy_d = 1'b1;
      sh_d   = {2'b11, fifo_data, 1'b0};
      nb_d   = two_stop ? 4'd11 : 4'd10;
      cnt_d  = div;
    end else if (tick) begin
      sh_d  = {1'b1, sh_q[FRAME_W-1:1]};
      nb_d  = nb_q - 4'd1;
      cnt_d = div;
      if (last) busy_d = 1'b0;
    end else if (busy_q) begin
      cnt_d = cnt_q - DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sh_q   <= '1;
      nb_q   <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      sh_q   <= sh_d;
      nb_q   <= nb_d;
      cnt_q  <= cnt_d;
    end
  end

  assign pop  = start;
  assign busy = busy_q;
  assign line = busy_q ? sh_q[0] : 1'b1;
endmodule

// File: rtl/wm_rx.sv
module wm_rx
  import uart_wm_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DIV_W-1:0]  div,
  input  logic              line,
  output logic              push,
  output logic [DATA_W-1:0] data
);
  logic [1:0]        sync_q;
  logic              rx_s;
  rx_state_e         st_q, st_d;
  logic [DIV_W-1:0]  cnt_q, cnt_d;
  logic [2:0]        bit_q, bit_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              at_zero;

  assign rx_s    = sync_q[1];
  assign at_zero = (cnt_q == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = at_zero ? cnt_q : cnt_q - DIV_W'(1);
    bit_d = bit_q;
    sh_d  = sh_q;
    push  = 1'b0;
    unique case (st_q)
      RX_IDLE: if (!rx_s) begin
        st_d  = RX_START;
        cnt_d = div >> 1;
      end
      RX_START: if (at_zero) begin
        st_d  = rx_s ? RX_IDLE : RX_DATA;
        cnt_d = div;
        bit_d = '0;
      end
      RX_DATA: if (at_zero) begin
        sh_d  = {rx_s, sh_q[DATA_W-1:1]};
        cnt_d = div;
        bit_d = bit_q + 3'd1;
        if (bit_q == 3'd7) st_d = RX_STOP;
      end
      RX_STOP: if (at_zero) begin
        push = rx_s && en;
        st_d = rx_s ? RX_IDLE : RX_WAIT;
      end
      RX_WAIT: if (rx_s) st_d = RX_IDLE;
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
    end else begin
      sync_q <= {sync_q[0], line};
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
    end
  end

  assign data = sh_q;
endmodule

// File: rtl/uart_wm.sv
module uart_wm
  import uart_wm_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DIV_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_we,
  input  logic [4:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        ser_tx,
  input  logic        ser_rx,
  output logic        irq
);
  localparam int CW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH+1);

  logic [1:0]        rst_sync_q;
  logic              rst_i_n;
  logic [2:0]        sel;
  logic              wr, rd;

  logic              tx_en_q, tx_en_d, stop2_q, stop2_d;
  logic [CW-1:0]     txwm_q, txwm_d, rxwm_q, rxwm_d;
  logic              rx_en_q, rx_en_d;
  logic [1:0]        ie_q, ie_d, ip;
  logic [DIV_W-1:0]  div_q, div_d;

  logic [DATA_W-1:0] tx_head, rx_head, rx_byte;
  logic [LW-1:0]     tx_count, rx_count;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              tx_push, tx_pop, rx_push, rx_pop, tx_busy;
  logic              unused_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  assign sel     = bus_addr[4:2];
  assign wr      = bus_req && bus_we;
  assign rd      = bus_req && !bus_we;
  assign tx_push = wr && (sel == SEL_TXD);
  assign rx_pop  = rd && (sel == SEL_RXD);

  always_comb begin
    tx_en_d = tx_en_q;
    stop2_d = stop2_q;
    txwm_d  = txwm_q;
    rx_en_d = rx_en_q;
    rxwm_d  = rxwm_q;
    ie_d    = ie_q;
    div_d   = div_q;
    if (wr) begin
      unique case (sel)
        SEL_TXC: begin
          tx_en_d = bus_wdata[0];
          stop2_d = bus_wdata[1];
          txwm_d  = bus_wdata[16 +: CW];
        end
        SEL_RXC: begin
          rx_en_d = bus_wdata[0];
          rxwm_d  = bus_wdata[16 +: CW];
        end
        SEL_IEN: ie_d  = bus_wdata[1:0];
        SEL_DIV: div_d = bus_wdata[DIV_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      tx_en_q <= 1'b0;
      stop2_q <= 1'b0;
      txwm_q  <= '0;
      rx_en_q <= 1'b0;
      rxwm_q  <= '0;
      ie_q    <= '0;
      div_q   <= '0;
    end else begin
      tx_en_q <= tx_en_d;
      stop2_q <= stop2_d;
      txwm_q  <= txwm_d;
      rx_en_q <= rx_en_d;
      rxwm_q  <= rxwm_d;
      ie_q    <= ie_d;
      div_q   <= div_d;
    end
  end

  assign ip[0] = tx_count < LW'(txwm_q);
  assign ip[1] = rx_count > LW'(rxwm_q);
  assign irq   = |(ie_q & ip);

  always_comb begin
    bus_rdata = '0;
    unique case (sel)
      SEL_TXD:  bus_rdata[31] = tx_full;
      SEL_RXD: begin
        bus_rdata[31] = rx_empty;
        bus_rdata[DATA_W-1:0] = rx_empty ? '0 : rx_head;
      end
      SEL_TXC: begin
        bus_rdata[0] = tx_en_q;
        bus_rdata[1] = stop2_q;
        bus_rdata[16 +: CW] = txwm_q;
      end
      SEL_RXC: begin
        bus_rdata[0] = rx_en_q;
        bus_rdata[16 +: CW] = rxwm_q;
      end
      SEL_IEN:  bus_rdata[1:0] = ie_q;
      SEL_IPND: bus_rdata[1:0] = ip;
      SEL_DIV:  bus_rdata[DIV_W-1:0] = div_q;
      default:  bus_rdata = '0;
    endcase
  end

  assign unused_bits = ^{bus_addr[1:0], bus_wdata, rx_full};

  wm_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_i_n), .push(tx_push), .wdata(bus_wdata[DATA_W-1:0]),
    .pop(tx_pop), .rdata(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  wm_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_i_n), .push(rx_push), .wdata(rx_byte),
    .pop(rx_pop), .rdata(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  wm_tx #(.DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_i_n), .en(tx_en_q), .two_stop(stop2_q), .div(div_q),
    .fifo_empty(tx_empty), .fifo_data(tx_head), .pop(tx_pop), .busy(tx_busy),
    .line(ser_tx)
  );

  wm_rx #(.DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_i_n), .en(rx_en_q), .div(div_q), .line(ser_rx),
    .push(rx_push), .data(rx_byte)
  );
endmodule

// File: rtl/uart_wm_chk.sv
module uart_wm_chk
  import uart_wm_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = 3,
  parameter int LW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_we,
  input logic [4:0]    bus_addr,
  input logic          ser_tx,
  input logic          irq,
  input logic          tx_busy,
  input logic          tx_pop,
  input logic          rx_push,
  input logic [LW-1:0] tx_count,
  input logic [LW-1:0] rx_count,
  input logic [1:0]    ip,
  input logic [1:0]    ie,
  input logic [CW-1:0] txwm
);
  assert_tx_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> ser_tx);

  assert_tx_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_tx) |-> tx_busy);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_we && bus_addr[4:2] == SEL_TXD && tx_count == LW'(DEPTH) && !tx_pop)
    |=> tx_count == LW'(DEPTH));

  assert_rx_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= LW'(DEPTH));

  assert_txwm_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_count == '0 && txwm != '0) |-> ip[0]);

  assert_rxwm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count == '0 |-> !ip[1]);

  assert_irq_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ie != 2'b00);

  assert_empty_pop_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_addr[4:2] == SEL_RXD && rx_count == '0 && !rx_push)
    |=> rx_count == '0);
endmodule

bind uart_wm uart_wm_chk #(.DEPTH(DEPTH), .CW(CW), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_i_n), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .ser_tx(ser_tx), .irq(irq), .tx_busy(tx_busy),
  .tx_pop(tx_pop), .rx_push(rx_push), .tx_count(tx_count), .rx_count(rx_count),
  .ip(ip), .ie(ie_q), .txwm(txwm_q)
);

// File: tb/uart_wm_test.sv
module uart_wm_test;
  localparam int BIT  = 4;   // divisor 3
  localparam int HALF = 2;

  logic        clk, rst_n, bus_req, bus_we, ser_rx;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        ser_tx, irq;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit quiet = 0, mon_on = 0;
  int stop_bad = 0;
  logic [7:0] got_q[$];
  int         start_q[$];
  logic [7:0] rx_q[$];
  int tx_level = 0, txwm_m = 0, rxwm_m = 0;
  logic [1:0] ie_m = 0;

  uart_wm uut (.clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ser_tx(ser_tx), .ser_rx(ser_rx), .irq(irq));

  initial clk = 0;
  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic model_irq();
    logic [1:0] p;
    p[0] = tx_level < txwm_m;
    p[1] = rx_q.size() > rxwm_m;
    return |(p & ie_m);
  endfunction

  // every-clock comparison while the model is settled (R10, R1)
  always @(negedge clk) if (quiet) begin
    chk("R10 irq", {31'b0, irq}, {31'b0, model_irq()});
    chk("R1 idle line", {31'b0, ser_tx}, 32'd1);
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 0; bus_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_req = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_req = 0;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic settle(input int n);
    quiet = 1;
    repeat (n) @(negedge clk);
    quiet = 0;
  endtask

  task automatic send(input logic [7:0] b, input logic stop);
    @(negedge clk);
    ser_rx = 0;
    repeat (BIT) @(negedge clk);
    for (int k = 0; k < 8; k++) begin
      ser_rx = b[k];
      repeat (BIT) @(negedge clk);
    end
    ser_rx = stop;
    repeat (BIT) @(negedge clk);
    ser_rx = 1;
    repeat (8) @(negedge clk);
  endtask

  task automatic rx_expect_pop(input string req);
    logic [7:0] e;
    e = rx_q.pop_front();
    rd_chk(req, 5'h04, {24'b0, e});
  endtask

  // serial monitor on the transmit line
  initial begin
    logic [7:0] b;
    int s;
    forever begin
      @(negedge clk);
      if (mon_on && ser_tx === 1'b0) begin
        s = cyc;
        repeat (HALF) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
          repeat (BIT) @(negedge clk);
          b[k] = ser_tx;
        end
        repeat (BIT) @(negedge clk);
        if (ser_tx !== 1'b1) stop_bad++;
        got_q.push_back(b);
        start_q.push_back(s);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] exp8 [8];
    rst_n = 0; bus_req = 0; bus_we = 0; bus_addr = 0; bus_wdata = 0; ser_rx = 1;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk("R1 ser_tx", {31'b0, ser_tx}, 32'd1);
    chk("R1 irq", {31'b0, irq}, 32'd0);
    rd_chk("R1 txdata", 5'h00, 32'h0);
    rd_chk("R1 rxdata", 5'h04, 32'h8000_0000);
    rd_chk("R1 txctrl", 5'h08, 32'h0);
    rd_chk("R1 rxctrl", 5'h0C, 32'h0);
    rd_chk("R1 ie", 5'h10, 32'h0);
    rd_chk("R1 ip", 5'h14, 32'h0);
    rd_chk("R1 div", 5'h18, 32'h0);
    settle(10);

    // R11 field readback
    wr(5'h18, 32'hABCD_0003);
    rd_chk("R11 div", 5'h18, 32'h0000_0003);
    wr(5'h08, 32'hFFFF_FFFF);
    rd_chk("R11 txctrl", 5'h08, 32'h0007_0003);
    wr(5'h0C, 32'hFFFF_FFFE);
    rd_chk("R11 rxctrl", 5'h0C, 32'h0007_0000);
    wr(5'h0C, 32'h0);
    wr(5'h10, 32'hFFFF_FFFC);
    rd_chk("R11 ie", 5'h10, 32'h0);

    // R4 queue while disabled, full flag, dropped write; R8 boundary
    wr(5'h08, 32'h0007_0000); txwm_m = 7;
    for (int i = 0; i < 8; i++) begin
      exp8[i] = 8'h30 + 8'(i * 37);
      wr(5'h00, {24'b0, exp8[i]});
      tx_level++;
    end
    rd_chk("R4 full flag", 5'h00, 32'h8000_0000);
    wr(5'h00, 32'hEE);
    settle(60);
    rd_chk("R8 ip at 8 vs 7", 5'h14, 32'h0);

    // R2 one stop bit, R4 drained contents
    mon_on = 1;
    wr(5'h08, 32'h0001_0001); txwm_m = 1;
    repeat (380) @(negedge clk);
    tx_level = 0;
    chk("R4 frame count", got_q.size(), 8);
    for (int i = 0; i < 8 && i < got_q.size(); i++)
      chk("R2 tx byte", {24'b0, got_q[i]}, {24'b0, exp8[i]});
    for (int i = 1; i < start_q.size(); i++)
      chk("R2 spacing", start_q[i] - start_q[i-1], 10 * BIT);
    chk("R2 stop bits high", stop_bad, 0);
    rd_chk("R4 not full", 5'h00, 32'h0);
    rd_chk("R8 ip drained", 5'h14, 32'h1);
    wr(5'h10, 32'h1); ie_m = 2'b01;
    settle(10);
    chk("R10 tx irq", {31'b0, irq}, 32'd1);
    wr(5'h10, 32'h0); ie_m = 2'b00;
    settle(5);

    // R3 two stop bits
    got_q.delete(); start_q.delete();
    wr(5'h08, 32'h0001_0003);
    wr(5'h00, 32'hA1); wr(5'h00, 32'hA2); wr(5'h00, 32'hA3);
    repeat (200) @(negedge clk);
    chk("R3 frame count", got_q.size(), 3);
    if (got_q.size() == 3) chk("R3 last byte", {24'b0, got_q[2]}, 32'hA3);
    for (int i = 1; i < start_q.size(); i++)
      chk("R3 spacing", start_q[i] - start_q[i-1], 11 * BIT);
    chk("R3 stop bits high", stop_bad, 0);
    settle(5);

    // R6 disabled receiver
    send(8'h11, 1'b1);
    rd_chk("R6 disabled rx", 5'h04, 32'h8000_0000);

    // R5 reception, R6 bad stop, R9, R10
    wr(5'h0C, 32'h1); rxwm_m = 0;
    send(8'h5A, 1'b1); rx_q.push_back(8'h5A);
    send(8'h33, 1'b0);
    send(8'hC3, 1'b1); rx_q.push_back(8'hC3);
    settle(5);
    rd_chk("R9 ip rx pending", 5'h14, 32'h3);
    wr(5'h10, 32'h2); ie_m = 2'b10;
    settle(10);
    chk("R10 rx irq", {31'b0, irq}, 32'd1);
    rx_expect_pop("R5 first byte");
    rx_expect_pop("R6 bad frame skipped");
    rd_chk("R12 empty read", 5'h04, 32'h8000_0000);
    rd_chk("R12 empty read again", 5'h04, 32'h8000_0000);
    rd_chk("R9 ip no rx", 5'h14, 32'h1);
    settle(5);
    send(8'h77, 1'b1); rx_q.push_back(8'h77);
    rx_expect_pop("R12 after empty read");
    wr(5'h10, 32'h0); ie_m = 2'b00;

    // R7 overflow, R9 boundary
    for (int i = 0; i < 9; i++) begin
      send(8'h20 + 8'(i), 1'b1);
      if (rx_q.size() < 8) rx_q.push_back(8'h20 + 8'(i));
    end
    wr(5'h0C, 32'h0007_0001); rxwm_m = 7;
    settle(5);
    rd_chk("R9 ip 8 vs 7", 5'h14, 32'h3);
    rx_expect_pop("R7 oldest");
    rd_chk("R9 ip 7 vs 7", 5'h14, 32'h1);
    for (int i = 0; i < 7; i++) rx_expect_pop("R7 order");
    rd_chk("R7 ninth dropped", 5'h04, 32'h8000_0000);
    settle(10);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule